// File: doc/BRIEF.md
# Debounced GPIO Input Port

An eight-pin input port whose pins each take one of two paths to a readable status word: a direct path, or a filter that accepts a new level only after it has been seen on a run of consecutive sample strobes. Pad signals first cross into the system clock domain through two flip-flops. The filter does not sample on every clock. It samples only on single-cycle strobe pulses supplied from outside, and a control bit selects either the slow strobe (nominally 1 kHz) or the fast strobe (nominally 32 kHz).

Software reaches the block through a small register window. The window holds the status word, a per-pin filter enable mask and a control register with the rate bit. A configuration input decides which reset clears the mask and the control register. They can be cleared by any system reset, or by the power-on/pin reset alone. For every pin, an event bus gives a one-clock pulse whenever the reported value of that pin changes.

Top module: `gpio_debounce_port`

## Requirements
- R1: After power-on reset (`por_rst_n` low), the filter enable mask (address 1) and the control register (address 2) read 0x00, so every pin reports its raw value.
- R2: With filtering on for a pin, the reported level changes only on the 8th consecutive selected strobe sample that differs from the current level, and not on the 7th.
- R3: A selected strobe sample that equals the current reported level restarts the count, so that 8 fresh differing samples are needed afterwards.
- R4: Control bit 0 selects the strobe. 0 means `strobe_slow` and 1 means `strobe_fast`. Pulses on the unselected strobe have no effect on any filter.
- R5: Address map: 0 is status (read only, writes ignored), 1 is the mask, 2 is control with bits 7:1 reading zero, and 3 reads zero.
- R6: Status bit i gives the filtered level when mask bit i is 1 and the synchronized raw level when mask bit i is 0.
- R7: While `keep_cfg` is 1, a system reset (`sys_rst_n` low) leaves the mask and control registers unchanged. While `keep_cfg` is 0, a system reset clears both registers.
- R8: A pad change reaches an unfiltered status bit after exactly two rising clock edges.
- R9: Turning filtering on for a pin whose input is steady keeps its reported level and raises no event.
- R10: `evt_bus` bit i pulses high for exactly one clock in the cycle in which status bit i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst_n | input | 1 | Power-on / external pin reset, active low, synchronous |
| sys_rst_n | input | 1 | Any other system reset, active low, synchronous |
| keep_cfg | input | 1 | 1: configuration registers are cleared only by `por_rst_n` |
| strobe_slow | input | 1 | Single-cycle slow sample strobe |
| strobe_fast | input | 1 | Single-cycle fast sample strobe |
| pad_in | input | 8 | Asynchronous pad levels |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| evt_bus | output | 8 | Per-pin change pulses |

## Verification
The case hardest to reach from the ports is a count that restarts partway through. A pin has to collect several differing samples, then see one agreeing sample, and then see a new run that stops one short of eight. Only the last case shows that the earlier samples were discarded. The bench reaches this by holding the pad steady for three clocks before each strobe pulse, so the synchronizer has settled before the sample is taken. It then sequences the slow strobe by hand, including the single agreeing sample between the two runs. The rate-select checks use the same method: the bench fires many pulses on the unselected strobe and confirms that the reported level has not moved.

// File: rtl/gpio_debounce_port.sv
module gpio_debounce_port #(
  parameter int WIDTH   = 8,
  parameter int SAMPLES = 8
) (
  input  logic             clk,
  input  logic             por_rst_n,
  input  logic             sys_rst_n,
  input  logic             keep_cfg,
  input  logic             strobe_slow,
  input  logic             strobe_fast,
  input  logic [WIDTH-1:0] pad_in,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] evt_bus
);
  localparam int CW = $clog2(SAMPLES);
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic             cfg_clr, dp_clr, strobe;
  logic [WIDTH-1:0] sync1, sync2, mask_q, filt_q, status, prev_q;
  logic             fast_q;

  assign cfg_clr = !por_rst_n || (!sys_rst_n && !keep_cfg);
  assign dp_clr  = !por_rst_n || !sys_rst_n;
  assign strobe  = fast_q ? strobe_fast : strobe_slow;

  always_ff @(posedge clk) begin
    if (cfg_clr) begin
      mask_q <= '0;
      fast_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == 2'd1) mask_q <= wr_data;
      if (addr == 2'd2) fast_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (dp_clr) begin
      sync1  <= '0;
      sync2  <= '0;
      prev_q <= '0;
    end else begin
      sync1  <= pad_in;
      sync2  <= sync1;
      prev_q <= status;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic          lvl;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (dp_clr) begin
        lvl <= 1'b0;
        cnt <= '0;
      end else if (!mask_q[i]) begin
        lvl <= sync2[i];
        cnt <= '0;
      end else if (strobe) begin
        if (sync2[i] == lvl) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          lvl <= sync2[i];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filt_q[i] = lvl;
  end

  assign status  = (mask_q & filt_q) | (~mask_q & sync2);
  assign evt_bus = status ^ prev_q;

  always_comb begin
    case (addr)
      2'd0:    rd_data = status;
      2'd1:    rd_data = mask_q;
      2'd2:    rd_data = {{(WIDTH-1){1'b0}}, fast_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_debounce_port_chk.sv
module gpio_debounce_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             por_rst_n,
  input logic             sys_rst_n,
  input logic             keep_cfg,
  input logic             strobe_slow,
  input logic             strobe_fast,
  input logic [WIDTH-1:0] pad_in,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] evt_bus,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] filt_q,
  input logic             fast_q
);
  logic       any_rst;
  logic [1:0] since;
  assign any_rst = !por_rst_n || !sys_rst_n;

  always_ff @(posedge clk) begin
    if (any_rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  AST_POR_CLEARS_CFG: assert property (@(posedge clk)
    !por_rst_n |=> (mask_q == '0 && !fast_q)); // R1

  AST_SYS_KEEPS_CFG: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!sys_rst_n && keep_cfg && !wr_en) |=> ($stable(mask_q) && $stable(fast_q))); // R7

  AST_SYS_CLEARS_CFG: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!sys_rst_n && !keep_cfg) |=> (mask_q == '0 && !fast_q)); // R7

  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk)
    (addr == 2'd2) |-> (rd_data[WIDTH-1:1] == '0)); // R5

  AST_RAW_LATENCY: assert property (@(posedge clk) disable iff (any_rst)
    (since >= 2'd2 && mask_q == '0 && addr == 2'd0) |-> (rd_data == $past(pad_in, 2))); // R8

  AST_EVT_MATCHES_CHANGE: assert property (@(posedge clk) disable iff (any_rst)
    (since >= 2'd1 && addr == 2'd0 && $past(addr) == 2'd0)
      |-> (evt_bus == (rd_data ^ $past(rd_data)))); // R10

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (any_rst)
    (since >= 2'd1 && !$past(strobe_slow) && !$past(strobe_fast))
      |-> (((filt_q ^ $past(filt_q)) & mask_q & $past(mask_q)) == '0)); // R2
endmodule

bind gpio_debounce_port gpio_debounce_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n), .keep_cfg(keep_cfg),
  .strobe_slow(strobe_slow), .strobe_fast(strobe_fast), .pad_in(pad_in),
  .wr_en(wr_en), .addr(addr), .rd_data(rd_data), .evt_bus(evt_bus),
  .mask_q(mask_q), .filt_q(filt_q), .fast_q(fast_q)
);

// File: tb/gpio_debounce_port_test.sv
module gpio_debounce_port_test;
  logic       clk = 1'b0;
  logic       por_rst_n = 1'b0, sys_rst_n = 1'b1, keep_cfg = 1'b0;
  logic       strobe_slow = 1'b0, strobe_fast = 1'b0, wr_en = 1'b0;
  logic [7:0] pad_in = 8'h00, wr_data = 8'h00;
  logic [1:0] addr = 2'd0;
  logic [7:0] rd_data, evt_bus;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_debounce_port uut (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n), .keep_cfg(keep_cfg),
    .strobe_slow(strobe_slow), .strobe_fast(strobe_fast), .pad_in(pad_in),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .evt_bus(evt_bus)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
    addr = a;
    #1;
    check(req, rd_data, exp);
    addr = 2'd0;
    #1;
  endtask

  task automatic pulse(bit fast, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (fast) strobe_fast = 1'b1; else strobe_slow = 1'b1;
      @(negedge clk);
      strobe_slow = 1'b0; strobe_fast = 1'b0;
    end
  endtask

  task automatic set_pad(logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    tick(3);
  endtask

  task automatic t_reset;
    por_rst_n = 1'b0;
    tick(3);
    por_rst_n = 1'b1;
    tick(3);
    rd_check("R1 mask", 2'd1, 8'h00);
    rd_check("R1 ctrl", 2'd2, 8'h00);
    rd_check("R1 status", 2'd0, 8'h00);
  endtask

  task automatic t_raw;
    @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk);
    rd_check("R8 one edge", 2'd0, 8'h00);
    @(negedge clk);
    rd_check("R8 two edges", 2'd0, 8'hA5);
    check("R10 pulse", evt_bus, 8'hA5);
    @(negedge clk);
    check("R10 one cycle", evt_bus, 8'h00);
  endtask

  task automatic t_regs;
    wr(2'd2, 8'hFF);
    rd_check("R5 ctrl high", 2'd2, 8'h01);
    rd_check("R5 addr3", 2'd3, 8'h00);
    wr(2'd0, 8'h00);
    rd_check("R5 status ro", 2'd0, 8'hA5);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_enable;
    @(negedge clk);
    addr = 2'd1; wr_data = 8'h0F; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0;
    #1;
    check("R9 no event", evt_bus, 8'h00);
    rd_check("R9 level", 2'd0, 8'hA5);
  endtask

  task automatic t_slow;
    set_pad(8'h5A);
    rd_check("R6 mixed", 2'd0, 8'h55);
    pulse(1'b1, 10);
    rd_check("R4 fast ignored", 2'd0, 8'h55);
    pulse(1'b0, 7);
    rd_check("R2 seven", 2'd0, 8'h55);
    pulse(1'b0, 1);
    check("R10 filtered evt", evt_bus, 8'h0F);
    rd_check("R2 eighth", 2'd0, 8'h5A);
  endtask

  task automatic t_restart;
    set_pad(8'h55);
    pulse(1'b0, 4);
    set_pad(8'h5A);
    pulse(1'b0, 1);
    set_pad(8'h55);
    pulse(1'b0, 7);
    rd_check("R3 restarted", 2'd0, 8'h5A);
    pulse(1'b0, 1);
    rd_check("R3 completes", 2'd0, 8'h55);
  endtask

  task automatic t_fast;
    wr(2'd2, 8'h01);
    set_pad(8'h5A);
    pulse(1'b0, 10);
    rd_check("R4 slow ignored", 2'd0, 8'h55);
    pulse(1'b1, 8);
    rd_check("R4 fast used", 2'd0, 8'h5A);
  endtask

  task automatic t_resets;
    @(negedge clk);
    keep_cfg = 1'b1; sys_rst_n = 1'b0;
    tick(2);
    sys_rst_n = 1'b1;
    tick(1);
    rd_check("R7 kept mask", 2'd1, 8'h0F);
    rd_check("R7 kept ctrl", 2'd2, 8'h01);
    keep_cfg = 1'b0; sys_rst_n = 1'b0;
    tick(2);
    sys_rst_n = 1'b1;
    tick(1);
    rd_check("R7 cleared mask", 2'd1, 8'h00);
    rd_check("R7 cleared ctrl", 2'd2, 8'h00);
    wr(2'd1, 8'hF0);
    @(negedge clk);
    keep_cfg = 1'b1; por_rst_n = 1'b0;
    tick(2);
    por_rst_n = 1'b1;
    tick(1);
    rd_check("R1 por over keep", 2'd1, 8'h00);
  endtask

  initial begin
    t_reset;
    t_raw;
    t_regs;
    t_enable;
    t_slow;
    t_restart;
    t_fast;
    t_resets;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule